// File: doc/BRIEF.md
# Software-Acknowledge Message Resource Tracker

This block sits at the receiving end of a broadcast messaging path. It takes each incoming message into a circular payload queue and gives the message one of eight software-acknowledge resources. The reply to the sender is held back until software on the local processors has finished with the message and frees that resource. Each stored entry carries, in its byte 15, a one-hot image of the resource it holds. Software scans for nonzero vectors to find unprocessed work. When a message is stored, an interrupt pulse goes toward the local processors, and a per-message flag chooses whether the second socket is signalled as well.

Each held resource has an acknowledge timer. If software does not free the resource in time, the block sends an error reply at once. The resource stays occupied until software also clears the resource's timeout bit. Software uses a single write-to-clear register, with one pending bit and one timeout bit per resource. Whichever event sends the reply, a message gets exactly one reply. The queue window lies between programmable first and last slot indices. The write tail wraps from the last slot back to the first.

Top module: `swack_msg_tracker`

## Requirements
- R1: After reset the acknowledge status is all zero, `msg_rdy` is 1, `q_tail` equals `cfg_first`, and no reply or interrupt is asserted.
- R2: An accepted message takes the lowest-numbered free resource r. Pending bit r (status bits 7:0, bit index r) reads 1 in the cycle after acceptance.
- R3: The message is written into slot `q_tail`, with bits 127:120 replaced by the one-hot vector `1<<r`. The tail then moves to the next slot, going from `cfg_last` back to `cfg_first`.
- R4: `msg_rdy` is 0 while all eight resources are held or the slot at the tail still holds a held message. A `msg_vld` in such a cycle changes no state.
- R5: In the cycle after each stored message, `intr_sock[0]` pulses for one cycle. `intr_sock[1]` pulses with it only when `msg_both` was 1.
- R6: Writing 1 to the pending bit of a resource that is waiting and not timed out frees it. In the next cycle that resource gives a one-cycle non-error reply carrying the stored sender. The entry's bits 127:120 then read zero.
- R7: With `cfg_tmo`=N nonzero, a resource still not freed at the N-th clock edge after its store reads timeout bit r+8 set in the next cycle. It also gives a one-cycle error reply in that cycle and stays held. With `cfg_tmo`=0 no timeout occurs.
- R8: A timed-out resource is freed by clearing its pending and timeout bits together, or by clearing the pending bit and later the timeout bit. Neither way sends a reply. Clearing only its timeout bit while its pending bit is set changes nothing.
- R9: A message gets at most one reply. When the pending bit is cleared at the same edge where the timer would expire, the clear wins: the reply is a non-error reply, and no timeout bit is set.
- R10: Write bits that name a free resource, or the timeout bit of a resource that has not timed out, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_first | input | IDX_W | First slot of the queue window |
| cfg_last | input | IDX_W | Last slot of the queue window |
| cfg_tmo | input | TMO_W | Acknowledge timeout in cycles, 0 disables |
| msg_vld | input | 1 | Incoming message valid |
| msg_rdy | output | 1 | Message can be accepted this cycle |
| msg_data | input | ENTRY_W | Message entry image |
| msg_src | input | SRC_W | Sender identity for the reply |
| msg_both | input | 1 | Signal both processor sockets |
| intr_sock | output | 2 | Interrupt pulses per socket |
| ack_wr | input | 1 | Write strobe for the acknowledge register |
| ack_wdata | input | 2*NRES | Write-one-to-clear bits: pending 7:0, timeout 15:8 |
| ack_status | output | 2*NRES | Pending bits 7:0, timeout bits 15:8 |
| rply_vld | output | NRES | One-cycle reply per resource |
| rply_err | output | NRES | Reply is an error (timeout) reply |
| rply_src | output | NRES*SRC_W | Sender of each resource's message |
| q_tail | output | IDX_W | Current write slot |
| rd_idx | input | IDX_W | Read slot index |
| rd_data | output | ENTRY_W | Contents of slot `rd_idx` |

## Verification
Two events can decide the same resource at one clock edge: the software clear of its pending bit and the expiry of its acknowledge timer. The bench drives a clear timed to land exactly on the expiring edge. It then requires a single non-error reply, no error flag and no timeout bit. A random phase with a short timeout mixes clears, expiries and new messages, and a cycle model built from the requirements judges every reply and status bit.

// File: rtl/swack_pkg.sv
package swack_pkg;

    localparam int VEC_LSB = 120;
    localparam int VEC_W   = 8;

    typedef enum logic [1:0] {
        RS_FREE  = 2'd0,
        RS_WAIT  = 2'd1,
        RS_TMO_P = 2'd2,
        RS_TMO_O = 2'd3
    } res_state_e;

    typedef struct packed {
        logic vld;
        logic err;
    } reply_t;

endpackage

// File: rtl/swack_grant.sv
module swack_grant #(
    parameter int N = 8
) (
    input  logic [N-1:0] free_vec,
    output logic [N-1:0] gnt,
    output logic         any_free
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
            end
        end
        any_free = |free_vec;
    end
endmodule

// File: rtl/swack_res_unit.sv
module swack_res_unit
    import swack_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int SRC_W = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [IDX_W-1:0] slot_in,
    input  logic [SRC_W-1:0] src_in,
    input  logic             clr_p,
    input  logic             clr_t,
    input  logic [TMO_W-1:0] cfg_tmo,
    output logic             pend,
    output logic             tmo,
    output logic             held,
    output logic             freed,
    output logic [IDX_W-1:0] slot,
    output logic [SRC_W-1:0] src,
    output reply_t           rply
);
    res_state_e       st;
    logic [TMO_W-1:0] cnt;
    logic             expire;

    assign expire = (cfg_tmo != '0) && (cnt == cfg_tmo - TMO_W'(1));
    assign pend   = (st == RS_WAIT) || (st == RS_TMO_P);
    assign tmo    = (st == RS_TMO_P) || (st == RS_TMO_O);
    assign held   = (st != RS_FREE);

    always_comb begin
        freed = 1'b0;
        case (st)
            RS_WAIT:  freed = clr_p;
            RS_TMO_P: freed = clr_p && clr_t;
            RS_TMO_O: freed = clr_t;
            default:  freed = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RS_FREE;
            cnt  <= '0;
            slot <= '0;
            src  <= '0;
            rply <= '0;
        end else begin
            rply <= '0;
            case (st)
                RS_FREE: begin
                    if (alloc) begin
                        st   <= RS_WAIT;
                        cnt  <= '0;
                        slot <= slot_in;
                        src  <= src_in;
                    end
                end
                RS_WAIT: begin
                    if (clr_p) begin
                        st       <= RS_FREE;
                        rply.vld <= 1'b1;
                    end else if (expire) begin
                        st       <= RS_TMO_P;
                        rply.vld <= 1'b1;
                        rply.err <= 1'b1;
                    end else begin
                        cnt <= cnt + TMO_W'(1);
                    end
                end
                RS_TMO_P: begin
                    if (clr_p && clr_t) st <= RS_FREE;
                    else if (clr_p)     st <= RS_TMO_O;
                end
                RS_TMO_O: begin
                    if (clr_t) st <= RS_FREE;
                end
                default: st <= RS_FREE;
            endcase
        end
    end
endmodule

// File: rtl/swack_payload_q.sv
module swack_payload_q
    import swack_pkg::*;
#(
    parameter int SLOTS   = 32,
    parameter int IDX_W   = 5,
    parameter int ENTRY_W = 256,
    parameter int NRES    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      cfg_first,
    input  logic [IDX_W-1:0]      cfg_last,
    input  logic                  wr_en,
    input  logic [ENTRY_W-1:0]    wr_data,
    input  logic [VEC_W-1:0]      wr_vec,
    input  logic [NRES-1:0]       rel_en,
    input  logic [NRES*IDX_W-1:0] rel_slot,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [IDX_W-1:0]      tail,
    output logic                  tail_busy,
    output logic [ENTRY_W-1:0]    rd_data
);
    logic [ENTRY_W-1:0] mem  [SLOTS];
    logic [SLOTS-1:0]   busy;
    logic [ENTRY_W-1:0] merged;
    logic [IDX_W-1:0]   tail_nxt;

    always_comb begin
        merged = wr_data;
        merged[VEC_LSB +: VEC_W] = wr_vec;
    end

    assign tail_nxt  = (tail == cfg_last) ? cfg_first : tail + IDX_W'(1);
    assign tail_busy = busy[tail];
    assign rd_data   = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= cfg_first;
            busy <= '0;
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else begin
            for (int r = 0; r < NRES; r++) begin
                if (rel_en[r]) begin
                    busy[rel_slot[r*IDX_W +: IDX_W]] <= 1'b0;
                    mem[rel_slot[r*IDX_W +: IDX_W]][VEC_LSB +: VEC_W] <= '0;
                end
            end
            if (wr_en) begin
                mem[tail]  <= merged;
                busy[tail] <= 1'b1;
                tail       <= tail_nxt;
            end
        end
    end
endmodule

// File: rtl/swack_msg_tracker.sv
module swack_msg_tracker
    import swack_pkg::*;
#(
    parameter int NRES    = 8,
    parameter int SLOTS   = 32,
    parameter int ENTRY_W = 256,
    parameter int SRC_W   = 16,
    parameter int TMO_W   = 16,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      cfg_first,
    input  logic [IDX_W-1:0]      cfg_last,
    input  logic [TMO_W-1:0]      cfg_tmo,
    input  logic                  msg_vld,
    output logic                  msg_rdy,
    input  logic [ENTRY_W-1:0]    msg_data,
    input  logic [SRC_W-1:0]      msg_src,
    input  logic                  msg_both,
    output logic [1:0]            intr_sock,
    input  logic                  ack_wr,
    input  logic [2*NRES-1:0]     ack_wdata,
    output logic [2*NRES-1:0]     ack_status,
    output logic [NRES-1:0]       rply_vld,
    output logic [NRES-1:0]       rply_err,
    output logic [NRES*SRC_W-1:0] rply_src,
    output logic [IDX_W-1:0]      q_tail,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [ENTRY_W-1:0]    rd_data
);
    logic [NRES-1:0]       held_v, pend_v, tmo_v, freed_v, gnt;
    logic [NRES*IDX_W-1:0] slot_v;
    logic                  any_free, tail_busy, accept;

    swack_grant #(.N(NRES)) u_grant (
        .free_vec (~held_v),
        .gnt      (gnt),
        .any_free (any_free)
    );

    assign msg_rdy = any_free && !tail_busy;
    assign accept  = msg_vld && msg_rdy;

    for (genvar r = 0; r < NRES; r++) begin : g_res
        reply_t rp;
        swack_res_unit #(.TMO_W(TMO_W), .SRC_W(SRC_W), .IDX_W(IDX_W)) u_res (
            .clk     (clk),
            .rst     (rst),
            .alloc   (accept && gnt[r]),
            .slot_in (q_tail),
            .src_in  (msg_src),
            .clr_p   (ack_wr && ack_wdata[r]),
            .clr_t   (ack_wr && ack_wdata[NRES + r]),
            .cfg_tmo (cfg_tmo),
            .pend    (pend_v[r]),
            .tmo     (tmo_v[r]),
            .held    (held_v[r]),
            .freed   (freed_v[r]),
            .slot    (slot_v[r*IDX_W +: IDX_W]),
            .src     (rply_src[r*SRC_W +: SRC_W]),
            .rply    (rp)
        );
        assign rply_vld[r] = rp.vld;
        assign rply_err[r] = rp.err;
    end

    swack_payload_q #(.SLOTS(SLOTS), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .NRES(NRES)) u_q (
        .clk       (clk),
        .rst       (rst),
        .cfg_first (cfg_first),
        .cfg_last  (cfg_last),
        .wr_en     (accept),
        .wr_data   (msg_data),
        .wr_vec    (VEC_W'(gnt)),
        .rel_en    (freed_v),
        .rel_slot  (slot_v),
        .rd_idx    (rd_idx),
        .tail      (q_tail),
        .tail_busy (tail_busy),
        .rd_data   (rd_data)
    );

    assign ack_status = {tmo_v, pend_v};

    always_ff @(posedge clk) begin
        if (rst) intr_sock <= '0;
        else     intr_sock <= {accept && msg_both, accept};
    end
endmodule

// File: rtl/swack_tracker_chk.sv
module swack_tracker_chk #(
    parameter int NRES  = 8,
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_vld,
    input logic              msg_rdy,
    input logic [1:0]        intr_sock,
    input logic [2*NRES-1:0] ack_status,
    input logic [NRES-1:0]   rply_vld,
    input logic [NRES-1:0]   rply_err,
    input logic [IDX_W-1:0]  q_tail
);
    p_reply_had_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (|rply_vld) |-> ((rply_vld & ~$past(ack_status[NRES-1:0])) == '0));

    p_err_marks_timeout_r7: assert property (@(posedge clk) disable iff (rst)
        (rply_err & ~ack_status[2*NRES-1:NRES]) == '0);

    p_err_is_reply_r7: assert property (@(posedge clk) disable iff (rst)
        (rply_err & ~rply_vld) == '0);

    p_full_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (&(ack_status[NRES-1:0] | ack_status[2*NRES-1:NRES])) |-> !msg_rdy);

    p_store_raises_intr_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_vld && msg_rdy) |=> intr_sock[0]);

    p_second_socket_r5: assert property (@(posedge clk) disable iff (rst)
        intr_sock[1] |-> intr_sock[0]);

    p_one_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(ack_status[NRES-1:0] & ~$past(ack_status[NRES-1:0])) <= 1);

    p_tail_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !(msg_vld && msg_rdy) |=> $stable(q_tail));
endmodule

bind swack_msg_tracker swack_tracker_chk #(.NRES(NRES), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_vld    (msg_vld),
    .msg_rdy    (msg_rdy),
    .intr_sock  (intr_sock),
    .ack_status (ack_status),
    .rply_vld   (rply_vld),
    .rply_err   (rply_err),
    .q_tail     (q_tail)
);

// File: tb/tb_swack_msg_tracker.sv
`timescale 1ns/1ps
module tb_swack_msg_tracker;
    localparam int NRES = 8, SLOTS = 32, IDX_W = 5, EW = 256, SW = 16, TW = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic [IDX_W-1:0] cfg_first = 5'd3, cfg_last = 5'd19, rd_idx = '0;
    logic [TW-1:0] cfg_tmo = '0;
    logic msg_vld = 1'b0, msg_both = 1'b0, ack_wr = 1'b0, msg_rdy;
    logic [EW-1:0] msg_data = '0, rd_data;
    logic [SW-1:0] msg_src = '0;
    logic [1:0] intr_sock;
    logic [2*NRES-1:0] ack_wdata = '0, ack_status;
    logic [NRES-1:0] rply_vld, rply_err;
    logic [NRES*SW-1:0] rply_src;
    logic [IDX_W-1:0] q_tail;

    always #2.5 clk = ~clk;

    swack_msg_tracker dut (.*);

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";

    bit m_pend[NRES], m_tmo[NRES];
    int m_cnt[NRES], m_slot[NRES];
    logic [SW-1:0] m_src[NRES];
    bit m_busy[SLOTS];
    logic [EW-1:0] m_mem[SLOTS];
    int m_tail;

    task automatic chk(string what, logic [EW-1:0] act, logic [EW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int r = 0; r < NRES; r++) if (!m_pend[r] && !m_tmo[r]) return r;
        return -1;
    endfunction

    function automatic bit m_rdy();
        return (lowest_free() >= 0) && !m_busy[m_tail];
    endfunction

    task automatic model_reset();
        for (int r = 0; r < NRES; r++) begin
            m_pend[r] = 0; m_tmo[r] = 0; m_cnt[r] = 0; m_slot[r] = 0; m_src[r] = '0;
        end
        for (int s = 0; s < SLOTS; s++) begin m_busy[s] = 0; m_mem[s] = '0; end
        m_tail = int'(cfg_first);
    endtask

    task automatic step(bit vld, logic [EW-1:0] data, logic [SW-1:0] src, bit both,
                        bit wr, logic [15:0] wd, int ridx);
        bit acc, cp, ct, fr, pold;
        int g;
        logic [NRES-1:0] e_vld, e_err;
        logic [1:0] e_intr;
        logic [2*NRES-1:0] e_stat;
        msg_vld = vld; msg_data = data; msg_src = src; msg_both = both;
        ack_wr = wr; ack_wdata = wd; rd_idx = IDX_W'(ridx);
        #1;
        chk("msg_rdy (R4)", EW'(msg_rdy), EW'(m_rdy()));
        chk("rd_data (R3)", rd_data, m_mem[ridx]);
        acc = vld && m_rdy();
        g = lowest_free();
        e_vld = '0; e_err = '0;
        for (int r = 0; r < NRES; r++) begin
            cp = wr && wd[r]; ct = wr && wd[r+8]; fr = 0;
            if (m_pend[r] && !m_tmo[r]) begin
                if (cp) begin m_pend[r] = 0; e_vld[r] = 1; fr = 1; end
                else if (cfg_tmo != 0 && m_cnt[r] == int'(cfg_tmo) - 1) begin
                    m_tmo[r] = 1; e_vld[r] = 1; e_err[r] = 1;
                end else m_cnt[r] = (m_cnt[r] + 1) & 16'hFFFF;
            end else if (m_tmo[r]) begin
                pold = m_pend[r];
                if (cp) m_pend[r] = 0;
                if (ct && (cp || !pold)) begin m_tmo[r] = 0; m_pend[r] = 0; fr = 1; end
            end
            if (fr) begin
                m_busy[m_slot[r]] = 0;
                m_mem[m_slot[r]][127:120] = 8'h00;
            end
        end
        if (acc) begin
            m_pend[g] = 1; m_tmo[g] = 0; m_cnt[g] = 0; m_src[g] = src; m_slot[g] = m_tail;
            m_mem[m_tail] = data;
            m_mem[m_tail][127:120] = 8'(1 << g);
            m_busy[m_tail] = 1;
            m_tail = (m_tail == int'(cfg_last)) ? int'(cfg_first) : m_tail + 1;
        end
        e_intr = {acc && both, acc};
        for (int r = 0; r < NRES; r++) begin e_stat[r] = m_pend[r]; e_stat[r+8] = m_tmo[r]; end
        @(posedge clk); #1;
        chk("ack_status (R2 R6 R7 R8 R10)", EW'(ack_status), EW'(e_stat));
        chk("rply_vld (R6 R9)", EW'(rply_vld), EW'(e_vld));
        chk("rply_err (R7 R9)", EW'(rply_err), EW'(e_err));
        chk("intr_sock (R5)", EW'(intr_sock), EW'(e_intr));
        chk("q_tail (R3)", EW'(q_tail), EW'(m_tail));
        for (int r = 0; r < NRES; r++)
            if (e_vld[r]) chk("rply_src (R6)", EW'(rply_src[r*SW +: SW]), EW'(m_src[r]));
        @(negedge clk);
    endtask

    function automatic logic [EW-1:0] rnd_data();
        logic [EW-1:0] d;
        for (int i = 0; i < 8; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    function automatic int rnd_idx();
        return int'(cfg_first) + int'($urandom % 17);
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, '0, rnd_idx());
    endtask

    task automatic send(logic [SW-1:0] src, bit both);
        step(1, rnd_data(), src, both, 0, '0, rnd_idx());
    endtask

    task automatic clr(logic [15:0] wd);
        step(0, '0, '0, 0, 1, wd, rnd_idx());
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        cur_req = "R1";
        chk("reset status R1", EW'(ack_status), '0);
        chk("reset ready R1", EW'(msg_rdy), EW'(1));
        chk("reset tail R1", EW'(q_tail), EW'(3));
        chk("reset reply R1", EW'(rply_vld), '0);
        chk("reset intr R1", EW'(intr_sock), '0);
        @(negedge clk);

        cur_req = "R2 R5";
        send(16'h0011, 1); send(16'h0022, 0); send(16'h0033, 1);
        cur_req = "R6";
        clr(16'h0002);
        cur_req = "R2";
        send(16'h0044, 0);
        cur_req = "R10";
        clr(16'h00FF);

        cur_req = "R4";
        for (int i = 0; i < 8; i++) send(16'(i), 0);
        send(16'h0099, 1);
        clr(16'h00FF);

        cur_req = "R3";
        for (int i = 0; i < 20; i++) begin send(16'(100 + i), i[0]); clr(16'h00FF); end

        cur_req = "R4";
        send(16'h0AAA, 0);
        for (int i = 0; i < 16; i++) begin send(16'(200 + i), 0); clr(16'h00FE); end
        send(16'h0BBB, 0);
        clr(16'h0001);

        cur_req = "R7";
        cfg_tmo = 16'd5;
        send(16'h0C01, 0);
        idle(7);
        cur_req = "R8";
        clr(16'h0001);
        clr(16'h0100);
        send(16'h0C02, 0);
        idle(6);
        clr(16'h0100);
        clr(16'h0101);

        cur_req = "R10";
        send(16'h0C03, 0);
        clr(16'h0100);
        clr(16'h0200);
        clr(16'h0001);

        cur_req = "R9";
        cfg_tmo = 16'd4;
        send(16'h0D01, 1);
        idle(3);
        clr(16'h0001);
        idle(5);

        cur_req = "R2 R3 R6 R7 R8 random";
        cfg_tmo = 16'd30;
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] wd;
            wd = 16'($urandom);
            step($urandom % 2 == 0, rnd_data(), 16'($urandom), $urandom % 2 == 0,
                 $urandom % 3 == 0, wd, rnd_idx());
        end
        clr(16'hFFFF);
        clr(16'hFFFF);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule